// File: doc/BRIEF.md
# Unaligned Load Extraction Unit

This block turns a byte-addressed load request into one or two reads of a memory port that only returns whole, aligned 64-bit words. It then builds the register value from the returned words. It picks the bytes the load addresses, moves them down to bit 0, and widens them to 64 bits with either zero fill or sign fill. It handles only one load at a time. A new request is accepted only after the previous result has been taken.

A load whose bytes cross a 64-bit word boundary normally costs two reads. The lower word is read first, then the next word. The two words are joined before the bytes are extracted. A per-request rotate option gives the older behaviour instead. That request reads only the addressed word and rotates it, so bytes past the top lane wrap around to lane 0 of the same word. A per-request fault option turns alignment into a hard rule. A load whose address is not a multiple of its size then performs no read and raises a one-cycle misalignment flag.

Top module: `load_align_unit`

## Requirements
- R1: After reset `req_ready` is 1 and `res_valid`, `rd_req_valid` and `misalign` are 0. `req_ready` is 1 only while no load is in progress, and it is 1 again in the cycle after a result is taken.
- R2: A load that fits inside one aligned word issues exactly one read. Its `rd_req_addr` equals `req_addr` with bits [2:0] cleared. A read address never has any of bits [2:0] set.
- R3: `req_size` 0, 1, 2 and 3 selects 1, 2, 4 and 8 bytes. Memory is little-endian: byte lane k is `rd_resp_data[8k+7:8k]` and holds address word+k. The byte at `req_addr` appears at `res_data[7:0]`, and the following bytes appear in ascending lanes. With `req_signed` = 0, the bits above the item are zero.
- R4: With `req_signed` = 1, the bits above the item are copies of the item's most significant bit.
- R5: If `rotate_mode` = 0 and (`req_addr[2:0]` + bytes) > 8, the unit issues two reads: first the lower word, then the lower word address + 8. The bytes after the lower word's lane 7 come from lanes 0 and up of the upper word.
- R6: With `rotate_mode` = 1, only the addressed word is read. Byte k of the result is lane (`req_addr[2:0]` + k) mod 8 of that word.
- R7: A load is misaligned when the low log2(bytes) bits of `req_addr` are not all zero. With `fault_en` = 1, a misaligned load is accepted but issues no read and produces no result. `misalign` is 1 in exactly the cycle after acceptance.
- R8: With `fault_en` = 1, an aligned load completes normally. With `fault_en` = 0, a misaligned load completes normally and `misalign` stays 0.
- R9: `res_valid` rises exactly one cycle after the response of the last required word. While `res_ready` is 0, `res_valid` and `res_data` hold steady.
- R10: While `rd_req_ready` is 0, `rd_req_valid` stays 1 and `rd_req_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Unit can accept a load |
| req_addr | input | ADDR_W | Byte address of the load |
| req_size | input | SZ_W | Log2 of the byte count |
| req_signed | input | 1 | Sign-extend the result |
| rotate_mode | input | 1 | Rotate within one word instead of reading the next word |
| fault_en | input | 1 | Refuse misaligned loads |
| rd_req_valid | output | 1 | Aligned word read request |
| rd_req_ready | input | 1 | Memory accepts the read |
| rd_req_addr | output | ADDR_W | Aligned word address |
| rd_resp_valid | input | 1 | Read data present |
| rd_resp_data | input | DW | Whole aligned word |
| res_valid | output | 1 | Load result present |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | DW | Extended load result |
| misalign | output | 1 | One-cycle misalignment flag |

## Verification
The first read request is due in the cycle after acceptance. It stays pending for as many cycles as `rd_req_ready` is held low. The misalignment flag is due exactly one cycle after acceptance, and the result exactly one cycle after the last word response. Each scenario task samples all ports at the falling edge and records the cycle index of every read, response, flag and result. It then compares those indices with the due cycles instead of waiting for "eventually". It also holds `res_ready` low for two cycles to see that the result stays put, and checks the read order and addresses of split loads.

// File: rtl/load_align_unit.sv
module load_align_unit #(
  parameter int ADDR_W = 32,
  parameter int DW     = 64,
  parameter int SZ_W   = $clog2($clog2(DW / 8) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SZ_W-1:0]   req_size,
  input  logic              req_signed,
  input  logic              rotate_mode,
  input  logic              fault_en,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_resp_valid,
  input  logic [DW-1:0]     rd_resp_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DW-1:0]     res_data,
  output logic              misalign
);
  localparam int LANES = DW / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int IDX_W = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_REQ_LO, S_WAIT_LO, S_REQ_HI, S_WAIT_HI, S_DONE} state_t;
  state_t state;

  logic [ADDR_W-1:0] base_q;
  logic [OFF_W-1:0]  off_q;
  logic [SZ_W-1:0]   size_q;
  logic              sgn_q, span_q;
  logic [DW-1:0]     lo_q, hi_q;

  logic       accept, mis_c, span_c;
  logic [OFF_W:0] end_c;

  assign req_ready    = (state == S_IDLE);
  assign accept       = req_valid && req_ready;
  assign mis_c        = (req_addr[OFF_W-1:0] & OFF_W'((1 << req_size) - 1)) != '0;
  assign end_c        = {1'b0, req_addr[OFF_W-1:0]} + (OFF_W+1)'(1 << req_size);
  assign span_c       = !rotate_mode && (end_c > (OFF_W+1)'(LANES));
  assign rd_req_valid = (state == S_REQ_LO) || (state == S_REQ_HI);
  assign rd_req_addr  = (state == S_REQ_HI) ? base_q + ADDR_W'(LANES) : base_q;
  assign res_valid    = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      misalign <= 1'b0;
      base_q   <= '0;
      off_q    <= '0;
      size_q   <= '0;
      sgn_q    <= 1'b0;
      span_q   <= 1'b0;
      lo_q     <= '0;
      hi_q     <= '0;
    end else begin
      misalign <= accept && fault_en && mis_c;
      case (state)
        S_IDLE: if (accept && !(fault_en && mis_c)) begin
          base_q <= {req_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
          off_q  <= req_addr[OFF_W-1:0];
          size_q <= req_size;
          sgn_q  <= req_signed;
          span_q <= span_c;
          state  <= S_REQ_LO;
        end
        S_REQ_LO: if (rd_req_ready) state <= S_WAIT_LO;
        S_WAIT_LO: if (rd_resp_valid) begin
          lo_q  <= rd_resp_data;
          hi_q  <= rd_resp_data;
          state <= span_q ? S_REQ_HI : S_DONE;
        end
        S_REQ_HI: if (rd_req_ready) state <= S_WAIT_HI;
        S_WAIT_HI: if (rd_resp_valid) begin
          hi_q  <= rd_resp_data;
          state <= S_DONE;
        end
        S_DONE: if (res_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [2*DW-1:0] shifted;
  logic [DW-1:0]   raw;
  logic [IDX_W-1:0] top_idx;
  logic             fill;

  assign shifted = {hi_q, lo_q} >> ({off_q, 3'b000});
  assign raw     = shifted[DW-1:0];
  assign top_idx = IDX_W'((8 << size_q) - 1);
  assign fill    = sgn_q & raw[top_idx];

  always_comb begin
    for (int i = 0; i < DW; i++)
      res_data[i] = (i <= int'(top_idx)) ? raw[i] : fill;
  end

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || rd_req_valid) |-> !req_ready);
  p_rd_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_addr[OFF_W-1:0] == '0));
  p_flag_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |=> !misalign);
  p_flag_noread_r7: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (!rd_req_valid && !res_valid));
  p_res_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));
  p_res_after_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(rd_resp_valid));
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
endmodule

// File: tb/tb_load_align_unit.sv
`timescale 1ns/1ps
module tb_load_align_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_signed = 1'b0, rotate_mode = 1'b0, fault_en = 1'b0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b1;
  logic [31:0] rd_req_addr;
  logic        rd_resp_valid = 1'b0;
  logic [63:0] rd_resp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [63:0] res_data;
  logic        misalign;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  load_align_unit dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_signed(req_signed), .rotate_mode(rotate_mode),
    .fault_en(fault_en),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .misalign(misalign)
  );

  function automatic logic [7:0] mb(input logic [31:0] a);
    logic [31:0] t;
    t = a * 37 + 11;
    return t[7:0] ^ a[15:8];
  endfunction

  function automatic logic [63:0] word_at(input logic [31:0] w);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = mb({w[31:3], 3'b000} + 32'(k));
    return r;
  endfunction

  function automatic logic [63:0] exp_load(input logic [31:0] addr, input int size,
                                           input bit sgn, input bit rot);
    logic [63:0] v;
    logic [31:0] a;
    int n;
    n = 1 << size;
    v = '0;
    for (int k = 0; k < n; k++) begin
      if (rot) a = {addr[31:3], 3'b000} + 32'((int'(addr[2:0]) + k) % 8);
      else     a = addr + 32'(k);
      v[8*k +: 8] = mb(a);
    end
    if (sgn && v[8*n-1])
      for (int b = 8 * n; b < 64; b++) v[b] = 1'b1;
    return v;
  endfunction

  always @(posedge clk) begin
    rd_resp_valid <= rd_req_valid && rd_req_ready;
    rd_resp_data  <= word_at(rd_req_addr);
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic run_load(input logic [31:0] addr, input int size, input bit sgn,
                          input bit rot, input bit flt, input bit stall,
                          input string rq);
    int n, nreads, last_resp, res_at, nmis, mis_at, exp_reads;
    bit mis, fault, span;
    logic [31:0] ra [2];
    logic [31:0] lo;
    logic [63:0] cap, expv;
    n = 1 << size;
    mis = (addr & 32'(n - 1)) != 0;
    fault = flt && mis;
    span = !rot && (int'(addr[2:0]) + n > 8);
    exp_reads = fault ? 0 : (span ? 2 : 1);
    lo = {addr[31:3], 3'b000};
    expv = exp_load(addr, size, sgn, rot);
    nreads = 0; last_resp = -1; res_at = -1; nmis = 0; mis_at = -1;
    ra[0] = '0; ra[1] = '0; cap = '0;

    @(negedge clk);
    chk(req_ready, "R1", "ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = addr; req_size = 2'(size);
    req_signed = sgn; rotate_mode = rot; fault_en = flt; res_ready = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      rd_req_ready = !(stall && i < 3);
      if (res_at >= 0 && i == res_at + 3) begin
        chk(!res_valid && req_ready, "R1", "idle after result taken",
            {62'd0, res_valid, req_ready}, 64'd1);
        break;
      end
      if (rd_req_valid && rd_req_ready) begin
        if (nreads < 2) ra[nreads] = rd_req_addr;
        nreads++;
      end
      if (rd_resp_valid) last_resp = i;
      if (misalign) begin nmis++; mis_at = i; end
      if (res_valid) begin
        if (res_at < 0) begin
          res_at = i; cap = res_data;
        end else begin
          chk(res_data == cap, "R9", "result held while not ready", res_data, cap);
          if (i == res_at + 2) res_ready = 1'b1;
        end
      end
      if (fault && i == 6) break;
    end
    res_ready = 1'b0;

    chk(nreads == exp_reads, fault ? "R7" : (span ? "R5" : "R2"), "read count",
        64'(nreads), 64'(exp_reads));
    if (exp_reads >= 1)
      chk(ra[0] == lo, span ? "R5" : "R2", "first read address", 64'(ra[0]), 64'(lo));
    if (exp_reads == 2)
      chk(ra[1] == lo + 32'd8, "R5", "second read address", 64'(ra[1]), 64'(lo + 32'd8));
    if (fault) begin
      chk(nmis == 1 && mis_at == 0, "R7", "misalign pulse count/cycle",
          64'(nmis * 100 + mis_at), 64'd100);
      chk(res_at < 0, "R7", "no result on fault", 64'(res_at), 64'hFFFF_FFFF_FFFF_FFFF);
    end else begin
      chk(nmis == 0, "R8", "no misalign flag", 64'(nmis), 64'd0);
      chk(cap == expv, rq, "result data", cap, expv);
      chk(res_at >= 0 && res_at == last_resp + 1, "R9", "result one cycle after last word",
          64'(res_at), 64'(last_resp + 1));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !res_valid && !rd_req_valid && !misalign, "R1", "reset state",
        {60'd0, req_ready, res_valid, rd_req_valid, misalign}, 64'h8);

    run_load(32'h100, 3, 0, 0, 0, 0, "R3");
    run_load(32'h105, 0, 1, 0, 0, 0, "R4");
    run_load(32'h10A, 0, 1, 0, 0, 0, "R4");
    run_load(32'h106, 1, 0, 0, 0, 0, "R3");
    run_load(32'h204, 2, 1, 0, 0, 0, "R4");
    run_load(32'h206, 2, 0, 0, 0, 1, "R5");
    run_load(32'h10B, 3, 1, 0, 0, 0, "R5");
    run_load(32'h207, 1, 1, 0, 0, 1, "R5");
    run_load(32'h306, 2, 0, 1, 0, 0, "R6");
    run_load(32'h303, 3, 1, 1, 0, 1, "R6");
    run_load(32'h131, 1, 0, 0, 1, 0, "R7");
    run_load(32'h13E, 3, 0, 1, 1, 0, "R7");
    run_load(32'h134, 2, 1, 0, 1, 0, "R8");
    run_load(32'h007, 1, 0, 0, 0, 0, "R8");
    run_load(32'h3FD, 2, 1, 0, 0, 1, "R5");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule